// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for every beat of one memory burst. A controller strobes `start_i` together with a start column, a burst length code and an ordering select; from the next cycle on, the block presents one column per cycle on `col_o`, qualified by `beat_vld_o`. It raises `beat_last_o` on the final beat. The burst length, the ordering and the start column are captured when the burst is accepted, so the controller may change these inputs freely while the burst runs.

The beats stay inside an aligned window whose size equals the burst length. The column bits above that window never change. In sequential order the low window bits count up from the start column and wrap. In interleaved order beat n is the start column with its low window bits XORed with n. A new read, write or precharge elsewhere in the controller shows up here as `intr_i`. It ends the running burst. If `start_i` is high in the same cycle, a new burst replaces the old one without a gap.

Top module: `burst_colgen`

## Requirements
- R1: After synchronous reset, and in every cycle where `beat_vld_o` is low, `beat_last_o` is low and `col_o` is zero.
- R2: A start is accepted when `start_i` is high and the block is idle, on its last beat, or sees `intr_i` in the same cycle. In the next cycle `beat_vld_o` is high and `col_o` equals the start column.
- R3: The `blen_i` code selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8. `beat_vld_o` stays high for exactly that many consecutive cycles unless the burst is interrupted. Column bits at position 3 and above stay constant for the whole burst.
- R4: `beat_last_o` is high on the final beat of a burst and on no other beat.
- R5: With `ilv_i` = 0 (sequential order), beat n keeps the start column's bits above the low log2(L) bits. Its low log2(L) bits equal (start low bits + n) mod L.
- R6: With `ilv_i` = 1 (interleaved order), beat n equals the start column XOR n.
- R7: A burst of length 1 gives one beat with `beat_last_o` high on that beat. Strobing a start every cycle then gives one beat per cycle.
- R8: Changes to `start_col_i`, `blen_i` and `ilv_i` while a burst runs have no effect on that burst.
- R9: `start_i` during a burst that is not on its last beat, without `intr_i`, is ignored. The running burst continues unchanged.
- R10: A start on the last beat begins the next burst in the following cycle, with no idle cycle between the two bursts.
- R11: `intr_i` without `start_i` during a burst drives `beat_vld_o` low in the next cycle.
- R12: `intr_i` together with `start_i` abandons the running burst. Beat 0 of the new burst follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Burst start strobe |
| intr_i | input | 1 | Interrupt strobe that ends the running burst |
| start_col_i | input | COL_W | Start column of the burst |
| blen_i | input | 2 | Burst length code (0:1, 1:2, 2:4, 3:8 beats) |
| ilv_i | input | 1 | Ordering select: 0 sequential, 1 interleaved |
| col_o | output | COL_W | Column address of the current beat |
| beat_vld_o | output | 1 | Current beat is valid |
| beat_last_o | output | 1 | Current beat is the last of its burst |

## Verification
Every output is registered once. A strobe sampled at one rising edge shows up on the outputs just after that same edge, and each later beat follows one edge after the one before. The driver changes the inputs at the falling edge and queues one expected output triple for the rising edge that comes next. The monitor takes one queue entry 1 ns after each rising edge and compares valid, last and column. Because of this, starts that are ignored, interrupts and back-to-back bursts are all checked at the exact cycle where the requirements place them.

// File: rtl/burst_colgen_pkg.sv
package burst_colgen_pkg;

  localparam int WIN_W = 3;

  typedef enum logic [1:0] {
    BL_1 = 2'd0,
    BL_2 = 2'd1,
    BL_4 = 2'd2,
    BL_8 = 2'd3
  } blen_e;

  function automatic logic [WIN_W-1:0] win_mask(input blen_e bl);
    case (bl)
      BL_1:    win_mask = 3'b000;
      BL_2:    win_mask = 3'b001;
      BL_4:    win_mask = 3'b011;
      default: win_mask = 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/burst_colgen_ctrl.sv
module burst_colgen_ctrl
  import burst_colgen_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             intr_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [1:0]       blen_i,
  input  logic             ilv_i,
  output logic             nxt_act,
  output logic             nxt_last,
  output logic [WIN_W-1:0] nxt_beat,
  output logic [WIN_W-1:0] nxt_mask,
  output logic [COL_W-1:0] nxt_base,
  output logic             nxt_ilv
);

  logic             act_q;
  logic [WIN_W-1:0] beat_q;
  logic [WIN_W-1:0] mask_q;
  logic [COL_W-1:0] base_q;
  logic             ilv_q;
  logic             on_last;
  logic             accept;

  assign on_last = act_q && (beat_q == mask_q);
  assign accept  = start_i && (!act_q || on_last || intr_i);

  always_comb begin
    nxt_act  = act_q;
    nxt_beat = beat_q;
    nxt_mask = mask_q;
    nxt_base = base_q;
    nxt_ilv  = ilv_q;
    if (accept) begin
      nxt_act  = 1'b1;
      nxt_beat = '0;
      nxt_mask = win_mask(blen_e'(blen_i));
      nxt_base = start_col_i;
      nxt_ilv  = ilv_i;
    end else if (intr_i || on_last || !act_q) begin
      nxt_act  = 1'b0;
      nxt_beat = '0;
    end else begin
      nxt_beat = beat_q + 1'b1;
    end
    nxt_last = nxt_act && (nxt_beat == nxt_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      beat_q <= '0;
      mask_q <= '0;
      base_q <= '0;
      ilv_q  <= 1'b0;
    end else begin
      act_q  <= nxt_act;
      beat_q <= nxt_beat;
      mask_q <= nxt_mask;
      base_q <= nxt_base;
      ilv_q  <= nxt_ilv;
    end
  end

endmodule

// File: rtl/burst_colgen_addr.sv
module burst_colgen_addr
  import burst_colgen_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base,
  input  logic [WIN_W-1:0] beat,
  input  logic [WIN_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);

  logic [WIN_W-1:0] seq_sum;
  assign seq_sum = base[WIN_W-1:0] + beat;

  for (genvar gi = 0; gi < COL_W; gi++) begin : g_bit
    if (gi < WIN_W) begin : g_win
      assign col[gi] = mask[gi] ? (ilv ? (base[gi] ^ beat[gi]) : seq_sum[gi])
                                : base[gi];
    end else begin : g_hi
      assign col[gi] = base[gi];
    end
  end

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
  import burst_colgen_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             intr_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [1:0]       blen_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o,
  output logic             beat_vld_o,
  output logic             beat_last_o
);

  logic             nxt_act;
  logic             nxt_last;
  logic [WIN_W-1:0] nxt_beat;
  logic [WIN_W-1:0] nxt_mask;
  logic [COL_W-1:0] nxt_base;
  logic             nxt_ilv;
  logic [COL_W-1:0] nxt_col;

  burst_colgen_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .intr_i     (intr_i),
    .start_col_i(start_col_i),
    .blen_i     (blen_i),
    .ilv_i      (ilv_i),
    .nxt_act    (nxt_act),
    .nxt_last   (nxt_last),
    .nxt_beat   (nxt_beat),
    .nxt_mask   (nxt_mask),
    .nxt_base   (nxt_base),
    .nxt_ilv    (nxt_ilv)
  );

  burst_colgen_addr #(.COL_W(COL_W)) u_addr (
    .base(nxt_base),
    .beat(nxt_beat),
    .mask(nxt_mask),
    .ilv (nxt_ilv),
    .col (nxt_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_vld_o  <= 1'b0;
      beat_last_o <= 1'b0;
      col_o       <= '0;
    end else begin
      beat_vld_o  <= nxt_act;
      beat_last_o <= nxt_last;
      col_o       <= nxt_act ? nxt_col : '0;
    end
  end

endmodule

// File: rtl/burst_colgen_chk.sv
module burst_colgen_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             intr_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [1:0]       blen_i,
  input logic             ilv_i,
  input logic [COL_W-1:0] col_o,
  input logic             beat_vld_o,
  input logic             beat_last_o
);

  logic take;
  assign take = start_i && (!beat_vld_o || beat_last_o || intr_i);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !beat_vld_o |-> (!beat_last_o && col_o == '0));

  assert_start_col_R2: assert property (@(posedge clk) disable iff (rst)
    take |=> (beat_vld_o && col_o == $past(start_col_i)));

  assert_burst_continues_R3: assert property (@(posedge clk) disable iff (rst)
    (beat_vld_o && !beat_last_o && !intr_i) |=> beat_vld_o);

  assert_upper_fixed_R3: assert property (@(posedge clk) disable iff (rst)
    (beat_vld_o && !beat_last_o && !intr_i) |=> (col_o[COL_W-1:3] == $past(col_o[COL_W-1:3])));

  assert_last_in_burst_R4: assert property (@(posedge clk) disable iff (rst)
    beat_last_o |-> beat_vld_o);

  assert_single_beat_R7: assert property (@(posedge clk) disable iff (rst)
    (take && blen_i == 2'd0) |=> beat_last_o);

  assert_intr_stops_R11: assert property (@(posedge clk) disable iff (rst)
    (intr_i && !start_i) |=> !beat_vld_o);

endmodule

bind burst_colgen burst_colgen_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/burst_colgen_test.sv
module burst_colgen_test;

  localparam int COL_W = 10;

  typedef struct {
    logic             vld;
    logic             last;
    logic [COL_W-1:0] col;
    string            tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic             intr_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [1:0]       blen_i = '0;
  logic             ilv_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             beat_vld_o;
  logic             beat_last_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t q[$];

  // reference model state
  bit               m_act = 1'b0;
  int               m_n = 0;
  int               m_len = 1;
  logic [COL_W-1:0] m_base = '0;
  bit               m_ilv = 1'b0;

  always #5 clk = ~clk;

  burst_colgen #(.COL_W(COL_W)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .intr_i(intr_i),
    .start_col_i(start_col_i), .blen_i(blen_i), .ilv_i(ilv_i),
    .col_o(col_o), .beat_vld_o(beat_vld_o), .beat_last_o(beat_last_o)
  );

  function automatic logic [COL_W-1:0] ref_col(input logic [COL_W-1:0] b, input int n,
                                               input int len, input bit il);
    logic [COL_W-1:0] m;
    m = COL_W'(len - 1);
    if (il) return b ^ COL_W'(n);
    return (b & ~m) | ((b + COL_W'(n)) & m);
  endfunction

  task automatic step(input logic s, input logic [COL_W-1:0] c, input logic [1:0] bl,
                      input logic il, input logic it, input string tag);
    exp_t e;
    bit on_last;
    start_i = s; start_col_i = c; blen_i = bl; ilv_i = il; intr_i = it;
    on_last = m_act && (m_n == m_len - 1);
    if (s && (!m_act || on_last || it)) begin
      m_act = 1'b1; m_n = 0; m_len = 1 << bl; m_base = c; m_ilv = il;
    end else if (it || on_last || !m_act) begin
      m_act = 1'b0; m_n = 0;
    end else begin
      m_n++;
    end
    e.vld  = m_act;
    e.last = m_act && (m_n == m_len - 1);
    e.col  = m_act ? ref_col(m_base, m_n, m_len, m_ilv) : '0;
    e.tag  = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, '0, 2'd0, 1'b0, 1'b0, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (beat_vld_o !== e.vld || beat_last_o !== e.last || col_o !== e.col) begin
          errors++;
          $display("FAIL %s: got vld=%0b last=%0b col=%h, expected vld=%0b last=%0b col=%h",
                   e.tag, beat_vld_o, beat_last_o, col_o, e.vld, e.last, e.col);
        end
      end
    end
  end

  // watchdog
  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (beat_vld_o !== 1'b0 || beat_last_o !== 1'b0 || col_o !== '0) begin
      errors++;
      $display("FAIL R1: got vld=%0b last=%0b col=%h, expected 0 0 000",
               beat_vld_o, beat_last_o, col_o);
    end
    rst = 1'b0;
    idle(2, "R1");

    // R7 single beat, then a start every cycle
    step(1'b1, 10'h3F5, 2'd0, 1'b0, 1'b0, "R7");
    idle(2, "R7");
    for (int i = 0; i < 4; i++) step(1'b1, COL_W'(10'h120 + i), 2'd0, 1'b0, 1'b0, "R7");
    idle(2, "R7");

    // R3 / R5 sequential, every length
    for (int b = 1; b < 4; b++) begin
      step(1'b1, 10'h3F5, 2'(b), 1'b0, 1'b0, "R5");
      idle((1 << b) + 1, "R3");
    end
    step(1'b1, 10'h0A2, 2'd3, 1'b0, 1'b0, "R2");
    idle(9, "R5");

    // R6 interleaved
    step(1'b1, 10'h2A3, 2'd3, 1'b1, 1'b0, "R6");
    idle(9, "R6");
    step(1'b1, 10'h1FE, 2'd2, 1'b1, 1'b0, "R6");
    idle(5, "R6");

    // R8 inputs change mid-burst
    step(1'b1, 10'h055, 2'd3, 1'b0, 1'b0, "R8");
    for (int i = 0; i < 7; i++) step(1'b0, COL_W'(10'h3A0 + i), 2'(i), 1'b1, 1'b0, "R8");
    idle(2, "R8");

    // R9 start mid-burst ignored
    step(1'b1, 10'h100, 2'd3, 1'b0, 1'b0, "R9");
    step(1'b0, '0, 2'd0, 1'b0, 1'b0, "R9");
    step(1'b1, 10'h222, 2'd1, 1'b1, 1'b0, "R9");
    idle(8, "R9");

    // R10 back-to-back on last beat
    step(1'b1, 10'h011, 2'd1, 1'b0, 1'b0, "R10");
    step(1'b0, '0, 2'd0, 1'b0, 1'b0, "R10");
    step(1'b1, 10'h0C7, 2'd2, 1'b1, 1'b0, "R10");
    idle(5, "R10");

    // R11 interrupt alone
    step(1'b1, 10'h040, 2'd3, 1'b0, 1'b0, "R11");
    idle(2, "R11");
    step(1'b0, '0, 2'd0, 1'b0, 1'b1, "R11");
    idle(3, "R11");
    step(1'b0, '0, 2'd0, 1'b0, 1'b1, "R11");
    idle(1, "R11");

    // R12 interrupt with start
    step(1'b1, 10'h2F0, 2'd3, 1'b0, 1'b0, "R12");
    step(1'b0, '0, 2'd0, 1'b0, 1'b0, "R12");
    step(1'b1, 10'h155, 2'd2, 1'b0, 1'b1, "R12");
    idle(6, "R12");

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule